// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a system watchdog clocked by the main clock but advanced only by a strobe from a separate slow oscillator. Once software arms it, a down counter is decremented once every prescaler-divided group of slow ticks. If software fails to refresh the counter before it drains, the block raises a one-cycle reset-request pulse. A reset-cause flag remembers that this pulse happened, across the resulting system reset.

All control goes through a single register write port. Every action is guarded by a 16-bit key written to the key slot: one key arms the watchdog, another reloads the counter, and a third opens the prescaler and reload slots for writing. Any other key value closes them again.

Each accepted configuration write then spends a fixed number of slow ticks marked busy while it crosses into the slow domain. Only after that does it take effect. Once armed, the watchdog cannot be stopped by any write; only a system reset disarms it.

Top module: `keyed_watchdog`

## Requirements
- R1: After system reset the watchdog is disarmed, the prescaler code is 0, the reload value is 0xFFF, both status bits are 0, `count` reads 0xFFF and `rst_req` is low. After power-on reset `wdg_cause` is 0.
- R2: Writing 0xCCCC to the key slot (`wr_sel`=0) arms the watchdog and loads the count from the active reload value. While armed, the count drops by one on every divisor-th slow tick.
- R3: With reload value R and divisor D, `rst_req` pulses high for exactly one clock cycle. This happens D*max(R,1) slow ticks after the last arm or refresh, and only once until the next system reset.
- R4: The divisor is 4 shifted left by the 3-bit prescaler code, so codes 0 to 5 give 4 to 128 and codes 6 and 7 both give 256.
- R5: Writing 0xAAAA to the key slot reloads the count from the active reload value and restarts the prescaler phase.
- R6: Once armed, no key value, including 0x0000 and arbitrary values, disarms the watchdog or disturbs the count.
- R7: Writes to the prescaler slot (`wr_sel`=1, data bits 2:0) and the reload slot (`wr_sel`=2, data bits 11:0) are accepted only after a 0x5555 key write. Any other key write relocks them, and a locked write is dropped.
- R8: An accepted prescaler write sets `status[0]`, and an accepted reload write sets `status[1]`. Each bit clears on the SYNC_TICKS-th slow tick after the write (default 2), and the new value takes effect in that same cycle.
- R9: A write to a slot whose status bit is set is dropped.
- R10: `wdg_cause` is set by `rst_req` and is not cleared by `rst_n`. It is cleared by `cause_clr` or by `por_n`, and a set takes priority over a clear.
- R11: `count` shows the current counter value at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| por_n | input | 1 | Power-on reset, active low; clears the cause flag |
| rst_n | input | 1 | System reset, active low |
| tick | input | 1 | One-cycle strobe per slow-oscillator period |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Slot: 0 key, 1 prescaler, 2 reload |
| wr_data | input | 16 | Write data |
| cause_clr | input | 1 | Clears the reset-cause flag |
| rst_req | output | 1 | One-cycle reset request |
| active | output | 1 | Watchdog armed |
| status | output | 2 | Bit 0 prescaler update busy, bit 1 reload update busy |
| count | output | 12 | Current counter value |
| wdg_cause | output | 1 | Last reset came from the watchdog |

## Verification
Timeouts are measured with several prescaler codes: 1, 3, 6 and the aliasing code 7. Reload values of 0, 1, 2 and 5 are also used, so that the reload-0 floor and the divisor saturation can be told apart from an off-by-one in the count. A mid-run refresh moves the expected pulse, which separates a refresh that restarts the prescaler phase from one that only reloads the count. Configuration writes are tried while locked, after a relocking key, and while a busy bit is set. These writes expose a lock or busy gate that fails to drop them, because any accepted write would alter the later timeout. Stray key values after arming, together with a second interval after the pulse, show whether the watchdog stays armed and fires only once.

// File: rtl/kwdg_pkg.sv
package kwdg_pkg;
  localparam logic [15:0] KEY_ARM  = 16'hCCCC;
  localparam logic [15:0] KEY_FEED = 16'hAAAA;
  localparam logic [15:0] KEY_OPEN = 16'h5555;
  localparam int PCODE_W = 3;
  localparam int DIV_W   = 9;

  typedef enum logic [1:0] {
    SEL_KEY = 2'd0,
    SEL_PRE = 2'd1,
    SEL_RLD = 2'd2
  } slot_e;

  // divisor = 4 << code, saturating at 256
  function automatic logic [DIV_W-1:0] div_of(input logic [PCODE_W-1:0] code);
    logic [2:0] sh;
    sh = (code > 3'd6) ? 3'd6 : code;
    return DIV_W'(4) << sh;
  endfunction
endpackage

// File: rtl/kwdg_keydec.sv
module kwdg_keydec
  import kwdg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [15:0] wr_data,
  output logic        arm_p,
  output logic        feed_p,
  output logic        unlocked,
  output logic        armed
);
  logic key_wr;
  assign key_wr = wr_en && (wr_sel == SEL_KEY);
  assign arm_p  = key_wr && (wr_data == KEY_ARM);
  assign feed_p = key_wr && (wr_data == KEY_FEED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      armed    <= 1'b0;
    end else begin
      if (key_wr) unlocked <= (wr_data == KEY_OPEN);
      if (arm_p)  armed    <= 1'b1;
    end
  end
endmodule

// File: rtl/kwdg_slot.sv
module kwdg_slot #(
  parameter int            W          = 12,
  parameter logic [W-1:0]  RST_VAL    = '1,
  parameter int            SYNC_TICKS = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_req,
  input  logic [W-1:0] wr_val,
  output logic         busy,
  output logic [W-1:0] value
);
  localparam int SW = $clog2(SYNC_TICKS + 1);
  localparam logic [SW-1:0] LAST = SW'(SYNC_TICKS - 1);

  logic [W-1:0]  shadow;
  logic [SW-1:0] sc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= RST_VAL;
      value  <= RST_VAL;
      busy   <= 1'b0;
      sc     <= '0;
    end else if (wr_req && !busy) begin
      shadow <= wr_val;
      busy   <= 1'b1;
      sc     <= '0;
    end else if (busy && tick) begin
      if (sc == LAST) begin
        value <= shadow;
        busy  <= 1'b0;
      end else begin
        sc <= sc + 1'b1;
      end
    end
  end
endmodule

// File: rtl/kwdg_core.sv
module kwdg_core #(
  parameter int CW = 12,
  parameter int PW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          armed,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic [PW-1:0] div,
  output logic [CW-1:0] cnt,
  output logic          fire
);
  logic [PW-1:0] pc;
  logic          spent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '1;
      pc    <= '0;
      fire  <= 1'b0;
      spent <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (load) begin
        cnt <= load_val;
        pc  <= '0;
      end else if (armed && tick) begin
        if (pc == div - 1'b1) begin
          pc <= '0;
          if (cnt <= CW'(1)) begin
            cnt <= '0;
            if (!spent) begin
              fire  <= 1'b1;
              spent <= 1'b1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end else begin
          pc <= pc + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwdg_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int SYNC_TICKS = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [15:0]      wr_data,
  input  logic             cause_clr,
  output logic             rst_req,
  output logic             active,
  output logic [1:0]       status,
  output logic [CNT_W-1:0] count,
  output logic             wdg_cause
);
  logic arm_p, feed_p, unlocked;
  logic pre_busy, rld_busy;
  logic [PCODE_W-1:0] pcode;
  logic [CNT_W-1:0]   rld;

  kwdg_keydec u_keys (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .arm_p(arm_p), .feed_p(feed_p), .unlocked(unlocked), .armed(active)
  );

  kwdg_slot #(.W(PCODE_W), .RST_VAL('0), .SYNC_TICKS(SYNC_TICKS)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .wr_req(wr_en && unlocked && (wr_sel == SEL_PRE)),
    .wr_val(wr_data[PCODE_W-1:0]), .busy(pre_busy), .value(pcode)
  );

  kwdg_slot #(.W(CNT_W), .RST_VAL('1), .SYNC_TICKS(SYNC_TICKS)) u_rld (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .wr_req(wr_en && unlocked && (wr_sel == SEL_RLD)),
    .wr_val(wr_data[CNT_W-1:0]), .busy(rld_busy), .value(rld)
  );

  kwdg_core #(.CW(CNT_W), .PW(DIV_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .armed(active),
    .load(arm_p || feed_p), .load_val(rld), .div(div_of(pcode)),
    .cnt(count), .fire(rst_req)
  );

  assign status = {rld_busy, pre_busy};

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)         wdg_cause <= 1'b0;
    else if (rst_req)   wdg_cause <= 1'b1;
    else if (cause_clr) wdg_cause <= 1'b0;
  end
endmodule

// File: rtl/kwdg_checker.sv
module kwdg_checker #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             por_n,
  input logic             rst_n,
  input logic             tick,
  input logic             wr_en,
  input logic             rst_req,
  input logic             active,
  input logic [1:0]       status,
  input logic [CNT_W-1:0] count,
  input logic             wdg_cause
);
  p_pulse_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  p_stays_armed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> active);
  p_busy_clears_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[0]) |-> $past(tick));
  p_rld_busy_from_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> $past(wr_en));
  p_count_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(count));
  p_cause_set_r10: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    rst_req |=> wdg_cause);
endmodule

bind keyed_watchdog kwdg_checker #(.CNT_W(CNT_W)) u_kwdg_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
  .rst_req(rst_req), .active(active), .status(status), .count(count),
  .wdg_cause(wdg_cause)
);

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;
  logic clk = 1'b0, por_n = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic wr_en = 1'b0, cause_clr = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [15:0] wr_data = 16'h0;
  logic rst_req, active, wdg_cause;
  logic [1:0] status;
  logic [11:0] count;

  int total = 0, bad = 0;
  int tick_total = 0;
  int exp_q[$];
  bit finished = 0;

  always #2 clk = ~clk;

  keyed_watchdog u_keyed_watchdog (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .cause_clr(cause_clr), .rst_req(rst_req),
    .active(active), .status(status), .count(count), .wdg_cause(wdg_cause)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1; tick_total++;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic sysrst();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  // R4 / R3: configure, arm, expect the pulse after exp_ticks
  task automatic timed_run(input logic [2:0] code, input logic [11:0] rl, input int exp_ticks);
    sysrst();
    wr(2'd0, 16'h5555);
    wr(2'd1, {13'd0, code});
    wr(2'd2, {4'd0, rl});
    ticks(2);
    chk("R8 status idle after sync", int'(status), 0);
    wr(2'd0, 16'hCCCC);
    exp_q.push_back(tick_total + exp_ticks);
    ticks(exp_ticks + 4);
    chk("R4 pulse consumed", exp_q.size(), 0);
  endtask

  // monitor: pop expected pulse tick index
  initial begin
    forever begin
      @(posedge clk); #1;
      if (rst_n && rst_req) begin
        total++;
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL R3 unexpected pulse actual=%0d expected=none", tick_total);
        end else begin
          int e;
          e = exp_q.pop_front();
          if (e != tick_total) begin
            bad++;
            $display("FAIL R3 pulse tick actual=%0d expected=%0d", tick_total, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 active", active, 0);
    chk("R1 status", int'(status), 0);
    chk("R1 count", int'(count), 12'hFFF);
    chk("R1 rst_req", rst_req, 0);
    chk("R1 cause", wdg_cause, 0);

    // R7: locked write dropped
    wr(2'd2, 16'd9);
    chk("R7 locked reload write", int'(status), 0);
    wr(2'd0, 16'h5555);
    wr(2'd2, 16'd5);
    chk("R8 reload busy set", int'(status), 2);
    wr(2'd2, 16'd9);          // R9: dropped while busy
    ticks(1);
    chk("R8 still busy after 1 tick", int'(status), 2);
    ticks(1);
    chk("R8 reload busy clear", int'(status), 0);
    wr(2'd1, 16'd1);          // divisor 8
    chk("R8 prescaler busy set", int'(status), 1);
    ticks(2);
    chk("R8 prescaler busy clear", int'(status), 0);

    // R2
    wr(2'd0, 16'hCCCC);
    chk("R2 armed", active, 1);
    chk("R2 count loaded (R9 drop)", int'(count), 5);
    ticks(20);
    chk("R11 count after 20 ticks", int'(count), 3);
    // R5
    wr(2'd0, 16'hAAAA);
    chk("R5 refresh reload", int'(count), 5);
    exp_q.push_back(tick_total + 40);
    // R6
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h1234);
    chk("R6 still armed", active, 1);
    chk("R6 count untouched", int'(count), 5);
    ticks(45);
    chk("R3 pulse seen", exp_q.size(), 0);
    chk("R3 count drained", int'(count), 0);
    chk("R10 cause set", wdg_cause, 1);
    ticks(50);                // R3: no second pulse
    sysrst();
    chk("R10 cause survives rst_n", wdg_cause, 1);
    chk("R1 disarmed after reset", active, 0);
    chk("R1 count after reset", int'(count), 12'hFFF);
    @(negedge clk); cause_clr = 1'b1;
    @(negedge clk); cause_clr = 1'b0;
    chk("R10 cause cleared", wdg_cause, 0);

    // R7 relock
    wr(2'd0, 16'h5555);
    wr(2'd0, 16'hAAAA);
    wr(2'd2, 16'd7);
    chk("R7 relocked write dropped", int'(status), 0);

    // R4 divisor variants and R3 reload floor
    timed_run(3'd7, 12'd0, 256);
    timed_run(3'd6, 12'd1, 256);
    timed_run(3'd3, 12'd2, 64);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule